// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is the byte-level command engine behind a serial NOR flash slave port. The SPI deserialiser sits in front of it and hands over one received byte per transfer. In the same transfer the engine returns one byte, built combinationally from its current state. The first byte of each chip-select frame is an opcode. Depending on that opcode, the engine does one of the following:

- It gathers address, dummy or mode bytes.
- It updates its write-enable latch.
- It answers a status or identification query.
- It streams array data from an auto-incrementing address.

Program and erase work is not done here. A separate array engine receives it as registered strobes: one request strobe carrying the opcode and the 24-bit address, and one write strobe for each program data byte. Array reads use a combinational port. The block presents an address and expects the array byte back in the same cycle.

Three things are fixed by parameters: the device size (a power of two), the 24-bit identification code and an optional 16-bit extension. The top byte of the identification code selects how many bytes the dual-I/O and quad-I/O reads collect.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the write-enable latch is clear, the engine is idle, `tx_byte` is 0x00 and neither `req_stb` nor `wr_stb` is high.
- R2: Opcodes 0x03, 0x02, 0xA2, 0x32, 0x20, 0x52 and 0xD8 take exactly three more bytes, which form a 24-bit address, most significant byte first.
- R3: Opcodes 0x0B, 0x3B and 0x6B take four more bytes: the three address bytes followed by one dummy byte. Only then does array data start.
- R4: When the identification code's top byte is 0xEF or 0x01, opcode 0xBB takes 4 more bytes and opcode 0xEB takes 6. For any other top byte, 0xBB takes 5 and 0xEB takes 8.
- R5: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Neither takes further bytes.
- R6: Opcode 0x05 is followed by one response byte. That byte carries the write-enable latch in bit 1, with every other bit 0.
- R7: Opcode 0x9F is followed by the identification code, most significant byte first, as three bytes. When the extension is nonzero, its high byte and then its low byte come next, for five bytes in total.
- R8: With the latch set, opcode 0x01 takes one byte and then clears the latch. With the latch clear, 0x01 is ignored and the next byte is decoded as an opcode.
- R9: In a read, each transfer returns `rd_data` for the address on `rd_addr`. The address then increments and wraps modulo the device size.
- R10: After a program opcode's address, each data byte produces a `wr_stb` in the following cycle. That strobe carries the byte and its address, and the address then increments. Completing the address also pulses `req_stb`, one cycle later, with the opcode and the full 24-bit address.
- R11: An erase opcode (0x20, 0x52, 0xD8) pulses `req_stb` when its address completes only if the write-enable latch is set. Otherwise no request is issued.
- R12: A `frame_start` pulse returns the engine to idle and clears its byte counters. The next byte is then decoded as an opcode.
- R13: Opcode 0x00 and unrecognised opcodes are ignored. Any transfer with no defined response (opcode, address, dummy or program byte) returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse when chip select becomes active |
| byte_vld | input | 1 | A received byte is present on `rx_byte` this cycle |
| rx_byte | input | 8 | Byte received from the deserialiser |
| tx_byte | output | 8 | Response byte for the current transfer |
| rd_addr | output | log2(DEV_BYTES) | Current array read address |
| rd_data | input | 8 | Array byte at `rd_addr`, same cycle |
| req_stb | output | 1 | Program or erase request strobe |
| req_op | output | 8 | Opcode of the request |
| req_addr | output | 24 | Address collected for the request |
| wr_stb | output | 1 | Program data byte strobe |
| wr_addr | output | log2(DEV_BYTES) | Address of the program data byte |
| wr_byte | output | 8 | Program data byte |

## Verification
The checker assumes that `frame_start` never coincides with a byte the design must act on. It treats `frame_start` as dominant and takes the next valid byte after it to be an opcode. It also assumes that `rd_data` is settled within the cycle in which `rd_addr` is presented. The bench drives `frame_start` only in cycles where `byte_vld` is low. Its array model is a pure function of the presented address, so `rd_data` always follows `rd_addr` combinationally. Inputs change on the falling edge. Responses are sampled within the same low phase, so each sample reflects the state reached by the previous byte.

// File: rtl/nor_seq_pkg.sv
// Shared types for the serial NOR command sequencer.
// Assumes byte-granular transfers; the opcode encodings below are fixed by behaviour.
package nor_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_RESP,
        ST_READ,
        ST_PROG
    } seq_st_e;

    typedef enum logic [3:0] {
        K_NONE,
        K_READ,
        K_READ_DUMMY,
        K_READ_DIO,
        K_READ_QIO,
        K_PROG,
        K_ERASE,
        K_WRSR,
        K_WEL_SET,
        K_WEL_CLR,
        K_STATUS,
        K_ID
    } op_kind_e;

    // Map an opcode byte onto its behavioural class.
    function automatic op_kind_e kind_of(input logic [7:0] op);
        case (op)
            8'h03:                   return K_READ;
            8'h0B, 8'h3B, 8'h6B:     return K_READ_DUMMY;
            8'hBB:                   return K_READ_DIO;
            8'hEB:                   return K_READ_QIO;
            8'h02, 8'hA2, 8'h32:     return K_PROG;
            8'h20, 8'h52, 8'hD8:     return K_ERASE;
            8'h01:                   return K_WRSR;
            8'h06:                   return K_WEL_SET;
            8'h04:                   return K_WEL_CLR;
            8'h05:                   return K_STATUS;
            8'h9F:                   return K_ID;
            default:                 return K_NONE;
        endcase
    endfunction

endpackage

// File: rtl/nor_seq_decode.sv
// Opcode decoder: classifies the opcode byte seen in idle and derives how
// many bytes to collect, or how long a response is.
// Assumes the manufacturer byte and extension presence are elaboration constants.
module nor_seq_decode
    import nor_seq_pkg::*;
#(
    parameter logic [7:0] MFR_BYTE = 8'hEF,
    parameter bit         HAS_EXT  = 1'b0
) (
    input  logic [7:0] op,
    input  logic       wel,
    output op_kind_e   kind,
    output logic [3:0] need,
    output logic       collect,
    output logic       respond,
    output logic [2:0] rsp_len
);
    localparam bit         SHORT_IO = (MFR_BYTE == 8'hEF) || (MFR_BYTE == 8'h01);
    localparam logic [3:0] DIO_N    = SHORT_IO ? 4'd4 : 4'd5;
    localparam logic [3:0] QIO_N    = SHORT_IO ? 4'd6 : 4'd8;
    localparam logic [2:0] ID_N     = HAS_EXT ? 3'd5 : 3'd3;

    // Byte counts and next-state hints for the current opcode.
    always_comb begin
        kind    = kind_of(op);
        need    = 4'd0;
        collect = 1'b0;
        respond = 1'b0;
        rsp_len = 3'd0;
        case (kind)
            K_READ, K_PROG, K_ERASE: begin need = 4'd3; collect = 1'b1; end
            K_READ_DUMMY:            begin need = 4'd4; collect = 1'b1; end
            K_READ_DIO:              begin need = DIO_N; collect = 1'b1; end
            K_READ_QIO:              begin need = QIO_N; collect = 1'b1; end
            K_WRSR:                  begin need = 4'd1; collect = wel; end
            K_STATUS:                begin rsp_len = 3'd1; respond = 1'b1; end
            K_ID:                    begin rsp_len = ID_N; respond = 1'b1; end
            default:                 ;
        endcase
    end
endmodule

// File: rtl/nor_seq_resp.sv
// Response byte multiplexer: picks the byte returned in the current transfer
// from array data, status or identification, else 0x00.
// Assumes rd_data is valid combinationally for the current read address.
module nor_seq_resp
    import nor_seq_pkg::*;
#(
    parameter logic [23:0] ID_CODE = 24'hEF4017,
    parameter logic [15:0] ID_EXT  = 16'h0000
) (
    input  seq_st_e    st,
    input  op_kind_e   kind,
    input  logic [2:0] pos,
    input  logic       wel,
    input  logic [7:0] rd_data,
    output logic [7:0] tx
);
    logic [7:0] id_byte;

    // Select the identification byte at the response position.
    always_comb begin
        case (pos)
            3'd0:    id_byte = ID_CODE[23:16];
            3'd1:    id_byte = ID_CODE[15:8];
            3'd2:    id_byte = ID_CODE[7:0];
            3'd3:    id_byte = ID_EXT[15:8];
            3'd4:    id_byte = ID_EXT[7:0];
            default: id_byte = 8'h00;
        endcase
    end

    // Final response mux by state.
    always_comb begin
        tx = 8'h00;
        if (st == ST_READ) begin
            tx = rd_data;
        end else if (st == ST_RESP) begin
            if (kind == K_ID) tx = id_byte;
            else              tx = {6'b0, wel, 1'b0};
        end
    end
endmodule

// File: rtl/nor_seq_addr.sv
// Array address counter: loaded when an address completes, stepped once per
// streamed byte, wrapping at 2**AW.
// Assumes the device size is a power of two.
module nor_seq_addr #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] cur
);
    // Load has priority; step wraps naturally in AW bits.
    always_ff @(posedge clk) begin
        if (!rst_n)    cur <= '0;
        else if (load) cur <= load_val;
        else if (step) cur <= cur + 1'b1;
    end
endmodule

// File: rtl/nor_cmd_seq.sv
// Top of the serial NOR command sequencer. One received byte per transfer;
// the response byte for that transfer is combinational from current state.
// Assumes DEV_BYTES is a power of two no larger than 2**24, and that
// frame_start is pulsed when chip select becomes active.
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int          DEV_BYTES = 1 << 20,
    parameter logic [23:0] ID_CODE   = 24'hEF4017,
    parameter logic [15:0] ID_EXT    = 16'h0000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_start,
    input  logic                          byte_vld,
    input  logic [7:0]                    rx_byte,
    output logic [7:0]                    tx_byte,
    output logic [$clog2(DEV_BYTES)-1:0]  rd_addr,
    input  logic [7:0]                    rd_data,
    output logic                          req_stb,
    output logic [7:0]                    req_op,
    output logic [23:0]                   req_addr,
    output logic                          wr_stb,
    output logic [$clog2(DEV_BYTES)-1:0]  wr_addr,
    output logic [7:0]                    wr_byte
);
    localparam int         AW      = $clog2(DEV_BYTES);
    localparam logic [7:0] MFR     = ID_CODE[23:16];
    localparam bit         HAS_EXT = (ID_EXT != 16'h0000);

    seq_st_e    st_q;
    logic [7:0] op_q;
    logic [3:0] need_q;
    logic [3:0] cnt_q;
    logic [2:0] pos_q;
    logic [2:0] rsp_len_q;
    logic       wel_q;
    logic [23:0] addr_sh_q;

    op_kind_e   dec_kind;
    logic [3:0] dec_need;
    logic       dec_collect;
    logic       dec_respond;
    logic [2:0] dec_rsp_len;
    op_kind_e   cur_kind;

    logic        take;
    logic        done;
    logic [23:0] addr_nxt;
    logic        addr_load;
    logic        addr_step;

    nor_seq_decode #(.MFR_BYTE(MFR), .HAS_EXT(HAS_EXT)) u_dec (
        .op      (rx_byte),
        .wel     (wel_q),
        .kind    (dec_kind),
        .need    (dec_need),
        .collect (dec_collect),
        .respond (dec_respond),
        .rsp_len (dec_rsp_len)
    );

    nor_seq_resp #(.ID_CODE(ID_CODE), .ID_EXT(ID_EXT)) u_resp (
        .st      (st_q),
        .kind    (cur_kind),
        .pos     (pos_q),
        .wel     (wel_q),
        .rd_data (rd_data),
        .tx      (tx_byte)
    );

    nor_seq_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load),
        .load_val (addr_nxt[AW-1:0]),
        .step     (addr_step),
        .cur      (rd_addr)
    );

    // Per-transfer qualifiers and the assembled address.
    always_comb begin
        cur_kind  = kind_of(op_q);
        take      = byte_vld && !frame_start;
        addr_nxt  = (cnt_q < 4'd3) ? {addr_sh_q[15:0], rx_byte} : addr_sh_q;
        done      = take && (st_q == ST_COLLECT) && (4'(cnt_q + 4'd1) == need_q);
        addr_load = done && (cur_kind inside {K_READ, K_READ_DUMMY, K_READ_DIO,
                                              K_READ_QIO, K_PROG});
        addr_step = take && ((st_q == ST_READ) || (st_q == ST_PROG));
    end

    // Main sequencer: state, counters, latch and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            op_q      <= 8'h00;
            need_q    <= 4'd0;
            cnt_q     <= 4'd0;
            pos_q     <= 3'd0;
            rsp_len_q <= 3'd0;
            wel_q     <= 1'b0;
            addr_sh_q <= 24'd0;
            req_stb   <= 1'b0;
            req_op    <= 8'h00;
            req_addr  <= 24'd0;
            wr_stb    <= 1'b0;
            wr_addr   <= '0;
            wr_byte   <= 8'h00;
        end else begin
            req_stb <= 1'b0;
            wr_stb  <= 1'b0;
            if (frame_start) begin
                st_q  <= ST_IDLE;
                cnt_q <= 4'd0;
                pos_q <= 3'd0;
            end else if (byte_vld) begin
                case (st_q)
                    ST_IDLE: begin
                        op_q      <= rx_byte;
                        cnt_q     <= 4'd0;
                        pos_q     <= 3'd0;
                        need_q    <= dec_need;
                        rsp_len_q <= dec_rsp_len;
                        if (dec_kind == K_WEL_SET) wel_q <= 1'b1;
                        if (dec_kind == K_WEL_CLR) wel_q <= 1'b0;
                        if (dec_collect)      st_q <= ST_COLLECT;
                        else if (dec_respond) st_q <= ST_RESP;
                    end
                    ST_COLLECT: begin
                        cnt_q <= cnt_q + 4'd1;
                        if (cnt_q < 4'd3) addr_sh_q <= addr_nxt;
                        if (done) begin
                            st_q <= ST_IDLE;
                            case (cur_kind)
                                K_READ, K_READ_DUMMY, K_READ_DIO, K_READ_QIO:
                                    st_q <= ST_READ;
                                K_PROG: begin
                                    st_q     <= ST_PROG;
                                    req_stb  <= 1'b1;
                                    req_op   <= op_q;
                                    req_addr <= addr_nxt;
                                end
                                K_ERASE: begin
                                    req_stb  <= wel_q;
                                    req_op   <= op_q;
                                    req_addr <= addr_nxt;
                                end
                                K_WRSR: wel_q <= 1'b0;
                                default: ;
                            endcase
                        end
                    end
                    ST_RESP: begin
                        pos_q <= pos_q + 3'd1;
                        if (3'(pos_q + 3'd1) == rsp_len_q) begin
                            st_q  <= ST_IDLE;
                            pos_q <= 3'd0;
                        end
                    end
                    ST_PROG: begin
                        wr_stb  <= 1'b1;
                        wr_byte <= rx_byte;
                        wr_addr <= rd_addr;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
// Checker for the command sequencer, bound into every instance of the top.
// Assumes frame_start dominates a coincident byte.
module nor_cmd_seq_chk
    import nor_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       frame_start,
    input logic       byte_vld,
    input logic [7:0] rx_byte,
    input logic [7:0] tx_byte,
    input logic       req_stb,
    input logic [7:0] req_op,
    input logic       wr_stb,
    input seq_st_e    st,
    input logic       wel
);
    // R5
    wren_sets_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && byte_vld && !frame_start && rx_byte == 8'h06) |=> wel);

    // R5
    wrdi_clears_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && byte_vld && !frame_start && rx_byte == 8'h04) |=> !wel);

    // R12
    frame_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (st == ST_IDLE));

    // R11
    erase_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stb && (req_op == 8'h20 || req_op == 8'h52 || req_op == 8'hD8)) |-> wel);

    // R10
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_stb && wr_stb));

    // R13
    quiet_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_COLLECT || st == ST_PROG) |-> (tx_byte == 8'h00));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!req_stb && !wr_stb && !wel && st == ST_IDLE));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .byte_vld    (byte_vld),
    .rx_byte     (rx_byte),
    .tx_byte     (tx_byte),
    .req_stb     (req_stb),
    .req_op      (req_op),
    .wr_stb      (wr_stb),
    .st          (st_q),
    .wel         (wel_q)
);

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 20;

    typedef struct packed {
        logic [3:0]  n;
        logic [63:0] tx;
        logic [63:0] ex;
    } vec_t;

    // One frame per entry; bytes most significant first.
    localparam vec_t VECS [10] = '{
        '{4'd2, 64'h0500_0000_0000_0000, 64'h0000_0000_0000_0000}, // R6 latch clear
        '{4'd1, 64'h0600_0000_0000_0000, 64'h0000_0000_0000_0000}, // R5 set
        '{4'd2, 64'h0500_0000_0000_0000, 64'h0002_0000_0000_0000}, // R6 latch set
        '{4'd1, 64'h0400_0000_0000_0000, 64'h0000_0000_0000_0000}, // R5 clear
        '{4'd2, 64'h0500_0000_0000_0000, 64'h0000_0000_0000_0000}, // R5 cleared
        '{4'd5, 64'h9F00_0000_0000_0000, 64'h00EF_4017_0000_0000}, // R7 short id
        '{4'd6, 64'h0300_0102_0000_0000, 64'h0000_0000_5958_0000}, // R2 read
        '{4'd7, 64'h0B00_0200_FF00_0000, 64'h0000_0000_0058_5900}, // R3 dummy
        '{4'd3, 64'hAB05_0000_0000_0000, 64'h0000_0000_0000_0000}, // R13 unknown
        '{4'd4, 64'h009F_0000_0000_0000, 64'h0000_EF40_0000_0000}  // R13 nop
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic byte_vld = 1'b0;
    logic [7:0] rx_byte = 8'h00;

    logic [7:0] tx_a, tx_b, rd_data_a, rd_data_b, req_op_a, req_op_b, wr_byte_a, wr_byte_b;
    logic [AW-1:0] rd_addr_a, rd_addr_b, wr_addr_a, wr_addr_b;
    logic [23:0] req_addr_a, req_addr_b;
    logic req_stb_a, req_stb_b, wr_stb_a, wr_stb_b;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int n_req = 0;
    int n_wr = 0;
    logic [7:0] last_op = 8'h00;
    logic [23:0] last_req_addr = 24'd0;
    logic [7:0] last_wbyte = 8'h00;
    logic [AW-1:0] last_waddr = '0;
    logic [7:0] ra, rb;

    function automatic logic [7:0] mem(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign rd_data_a = mem(rd_addr_a);
    assign rd_data_b = mem(rd_addr_b);

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_seq #(.DEV_BYTES(1 << AW), .ID_CODE(24'hEF4017), .ID_EXT(16'h0000)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_vld(byte_vld),
        .rx_byte(rx_byte), .tx_byte(tx_a), .rd_addr(rd_addr_a), .rd_data(rd_data_a),
        .req_stb(req_stb_a), .req_op(req_op_a), .req_addr(req_addr_a),
        .wr_stb(wr_stb_a), .wr_addr(wr_addr_a), .wr_byte(wr_byte_a)
    );

    nor_cmd_seq #(.DEV_BYTES(1 << AW), .ID_CODE(24'h20BA18), .ID_EXT(16'h4D01)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_vld(byte_vld),
        .rx_byte(rx_byte), .tx_byte(tx_b), .rd_addr(rd_addr_b), .rd_data(rd_data_b),
        .req_stb(req_stb_b), .req_op(req_op_b), .req_addr(req_addr_b),
        .wr_stb(wr_stb_b), .wr_addr(wr_addr_b), .wr_byte(wr_byte_b)
    );

    // Strobe monitor on the primary instance, sampled mid-cycle.
    always @(negedge clk) begin
        if (req_stb_a) begin
            n_req <= n_req + 1;
            last_op <= req_op_a;
            last_req_addr <= req_addr_a;
        end
        if (wr_stb_a) begin
            n_wr <= n_wr + 1;
            last_wbyte <= wr_byte_a;
            last_waddr <= wr_addr_a;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        byte_vld = 1'b0;
        @(posedge clk);
        #1 frame_start = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] b);
        @(negedge clk);
        rx_byte = b;
        byte_vld = 1'b1;
        #1;
        ra = tx_a;
        rb = tx_b;
        @(posedge clk);
        #1 byte_vld = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int r0, w0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();
        // R1 reset state at the ports
        check("R1 tx", {24'd0, tx_a}, 32'h00);
        check("R1 strobes", {30'd0, req_stb_a, wr_stb_a}, 32'h0);

        for (int i = 0; i < 10; i++) begin
            frame();
            for (int j = 0; j < int'(VECS[i].n); j++) begin
                xfer(VECS[i].tx[63 - 8*j -: 8]);
                check($sformatf("R%0d vec%0d byte%0d", (i==5)?7:(i==6)?2:(i==7)?3:(i>=8)?13:(i==0||i==2)?6:5, i, j),
                      {24'd0, ra}, {24'd0, VECS[i].ex[63 - 8*j -: 8]});
            end
        end

        // R4 dual I/O read: short count on EF part, long count on other part
        frame();
        xfer(8'hBB); xfer(8'h00); xfer(8'h03); xfer(8'h00); xfer(8'hA5);
        xfer(8'h00);
        check("R4 dio short", {24'd0, ra}, {24'd0, mem(20'h00300)});
        check("R4 dio long pending", {24'd0, rb}, 32'h0);
        xfer(8'h00);
        check("R4 dio long", {24'd0, rb}, {24'd0, mem(20'h00300)});

        // R4 quad I/O read
        frame();
        xfer(8'hEB); xfer(8'h00); xfer(8'h04);
        for (int k = 0; k < 4; k++) xfer(8'h00);
        xfer(8'h00);
        check("R4 qio short", {24'd0, ra}, {24'd0, mem(20'h00400)});
        check("R4 qio long pending", {24'd0, rb}, 32'h0);
        xfer(8'h00); xfer(8'h00);
        check("R4 qio long", {24'd0, rb}, {24'd0, mem(20'h00400)});

        // R7 extended identification on the second instance
        frame();
        xfer(8'h9F); xfer(8'h00); check("R7 ext b0", {24'd0, rb}, 32'h20);
        xfer(8'h00); check("R7 ext b1", {24'd0, rb}, 32'hBA);
        xfer(8'h00); check("R7 ext b2", {24'd0, rb}, 32'h18);
        xfer(8'h00); check("R7 ext b3", {24'd0, rb}, 32'h4D);
        xfer(8'h00); check("R7 ext b4", {24'd0, rb}, 32'h01);

        // R9 wrap at the top of the device
        frame();
        xfer(8'h03); xfer(8'h0F); xfer(8'hFF); xfer(8'hFF);
        xfer(8'h00); check("R9 last", {24'd0, ra}, {24'd0, mem(20'hFFFFF)});
        xfer(8'h00); check("R9 wrap", {24'd0, ra}, {24'd0, mem(20'h00000)});

        // R8 ignored with latch clear: 0x9F after it is an opcode
        frame();
        xfer(8'h01); xfer(8'h9F); xfer(8'h00);
        check("R8 ignored", {24'd0, ra}, 32'hEF);

        // R8 with latch set: one byte collected, latch cleared
        frame(); xfer(8'h06);
        frame(); xfer(8'h01); xfer(8'h9F); xfer(8'h00);
        check("R8 byte taken", {24'd0, ra}, 32'h00);
        frame(); xfer(8'h05); xfer(8'h00);
        check("R8 latch cleared", {24'd0, ra}, 32'h00);

        // R11 erase with latch clear issues no request
        r0 = n_req;
        frame(); xfer(8'h20); xfer(8'h01); xfer(8'h00); xfer(8'h00);
        settle();
        check("R11 blocked", n_req - r0, 0);

        // R11 erase with latch set
        frame(); xfer(8'h06);
        r0 = n_req;
        frame(); xfer(8'hD8); xfer(8'h01); xfer(8'h00); xfer(8'h00);
        settle();
        check("R11 issued", n_req - r0, 1);
        check("R11 op", {24'd0, last_op}, 32'hD8);
        check("R2 erase addr", {8'd0, last_req_addr}, 32'h010000);

        // R10 program: request then two data strobes
        r0 = n_req; w0 = n_wr;
        frame(); xfer(8'h02); xfer(8'h12); xfer(8'h34); xfer(8'h56);
        xfer(8'hAA);
        check("R13 prog data tx", {24'd0, ra}, 32'h00);
        xfer(8'hBB);
        settle();
        check("R10 req count", n_req - r0, 1);
        check("R10 req addr", {8'd0, last_req_addr}, 32'h123456);
        check("R10 wr count", n_wr - w0, 2);
        check("R10 wr byte", {24'd0, last_wbyte}, 32'hBB);
        check("R10 wr addr", {12'd0, last_waddr}, 32'h23457);

        // R12 frame in mid-address: next byte is an opcode
        frame(); xfer(8'h03); xfer(8'h00); xfer(8'h00);
        frame(); xfer(8'h9F); xfer(8'h00);
        check("R12 restart", {24'd0, ra}, 32'hEF);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule